// File: doc/BRIEF.md
# Pseudo-SRAM Power Mode Sequencer

This block sits next to the access controller of a pseudo-SRAM and owns the memory's power state. It drives the active-low deep-power-down pin and a chip-enable override, which keeps the chip deselected while the memory cannot be used. It also drives a ready flag that gates the access controller.

After reset the sequencer keeps the pin high and counts a fixed initialisation wait. The wait defaults to 200 µs, and its length in clock cycles comes from the clock frequency parameter. The ready flag rises only once that wait has run out. A deep-power-down request pulls the pin low at once. A wake request raises the pin again and starts a second wait of the same length before the ready flag returns. Entering deep power down destroys the memory contents, so the sequencer raises a sticky contents-lost flag that the host clears with a pulse.

All requests are single-cycle pulses on plain control pins, and every output comes from a register, so no handshake is involved. While the chip-enable override is high the chip stays in standby, where it keeps its data and needs no wait. A deep-power-down request that arrives during a wait is stored and acted on when that wait ends.

Top module: `psram_pwr_seq`

## Requirements
- R1: While reset is asserted, `dpd_pin_n` is 1, `ce_force_high` is 1, `mem_ready` is 0 and `contents_lost` is 0.
- R2: The wait length W is computed as ceil(CLK_FREQ_HZ/1000 × WAIT_US / 1000) cycles. After reset is released, `mem_ready` is 0 for the first W-1 sampled cycles and is 1 from cycle W onward.
- R3: In the ready state, a `dpd_req` pulse makes `dpd_pin_n` 0, `mem_ready` 0 and `ce_force_high` 1 on the cycle after the pulse.
- R4: `contents_lost` becomes 1 on the cycle the chip enters deep power down. It stays 1 until a `lost_clr` pulse, which clears it on the next cycle. When entry and `lost_clr` fall in the same cycle, the flag is set.
- R5: In deep power down, a `wake_req` pulse makes `dpd_pin_n` 1 on the next cycle while `mem_ready` stays 0 and `ce_force_high` stays 1. `mem_ready` rises W+1 cycles after the pulse.
- R6: A `dpd_req` pulse seen during either wait is held. When the wait ends, the chip goes to deep power down instead of the ready state: `dpd_pin_n` falls on the cycle `mem_ready` would have risen, and `mem_ready` stays 0.
- R7: `wake_req` has no effect during the initialisation wait or in the ready state. `dpd_req` has no effect while the chip is already in deep power down.
- R8: `ce_force_high` is 1 in every state except ready, including the whole wake-up wait, and 0 in ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (power-on) |
| dpd_req | input | 1 | Pulse: request deep power down |
| wake_req | input | 1 | Pulse: request wake from deep power down |
| lost_clr | input | 1 | Pulse: clear the contents-lost flag |
| dpd_pin_n | output | 1 | Level for the memory's deep-power-down pin (0 = deep power down) |
| ce_force_high | output | 1 | Hold the memory chip enable deasserted (high) |
| mem_ready | output | 1 | Memory may be accessed |
| contents_lost | output | 1 | Sticky: memory contents are invalid |

## Verification
Every output is a register, so a request pulse driven on a falling edge takes effect one cycle later. On that cycle `dpd_pin_n`, `ce_force_high` and `contents_lost` change. `mem_ready` rises exactly W cycles after reset release and W+1 cycles after a wake pulse, and the bench also checks the cycle just before each rise. The driver stamps each expected output set with the cycle it is due. The monitor samples 1 ns after each rising edge and compares only the entries whose cycle has come; an entry whose cycle has passed unchecked counts as a failure.

// File: rtl/psram_pwr_pkg.sv
package psram_pwr_pkg;

  typedef enum logic [1:0] {
    PS_INIT  = 2'd0,
    PS_READY = 2'd1,
    PS_DEEP  = 2'd2,
    PS_EXIT  = 2'd3
  } pwr_state_e;

  // Cycles needed to cover us_len microseconds at freq_hz, rounded up, at least 1
  function automatic int wait_cycles(input longint freq_hz, input longint us_len);
    longint raw;
    raw = ((freq_hz / 1000) * us_len + 999) / 1000;
    if (raw < 1) raw = 1;
    return int'(raw);
  endfunction

endpackage

// File: rtl/pwr_wait_timer.sv
module pwr_wait_timer #(
  parameter int CYCLES = 40000,
  parameter int CNT_W  = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic done
);
  localparam logic [CNT_W-1:0] START = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= START;
    else if (load)           cnt_q <= START;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R5
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !load |=> done);

endmodule

// File: rtl/pwr_req_hold.sv
module pwr_req_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic in_wait,
  input  logic req,
  output logic pending
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (in_wait)  pend_q <= pend_q | req;
    else               pend_q <= 1'b0;
  end

  assign pending = pend_q;

  // R6
  pend_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && in_wait |=> pend_q);

endmodule

// File: rtl/pwr_lost_flag.sv
module pwr_lost_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic lost
);
  logic lost_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lost_q <= 1'b0;
    else if (set)  lost_q <= 1'b1;
    else if (clr)  lost_q <= 1'b0;
  end

  assign lost = lost_q;

  // R4
  lost_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> lost_q);

  // R4
  lost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lost_q && !clr |=> lost_q);

endmodule

// File: rtl/psram_pwr_seq.sv
module psram_pwr_seq
  import psram_pwr_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 200_000_000,
  parameter int WAIT_US     = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dpd_req,
  input  logic wake_req,
  input  logic lost_clr,
  output logic dpd_pin_n,
  output logic ce_force_high,
  output logic mem_ready,
  output logic contents_lost
);
  localparam int WAIT_CYC = wait_cycles(longint'(CLK_FREQ_HZ), longint'(WAIT_US));
  localparam int CNT_W    = $clog2(WAIT_CYC + 1);

  pwr_state_e state_q, state_d;
  logic       in_wait, tmr_load, tmr_done, pend, enter_deep;

  assign in_wait  = (state_q == PS_INIT) || (state_q == PS_EXIT);
  assign tmr_load = (state_q == PS_DEEP) && wake_req;

  pwr_wait_timer #(.CYCLES(WAIT_CYC), .CNT_W(CNT_W)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (tmr_load),
    .done  (tmr_done)
  );

  pwr_req_hold u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_wait (in_wait),
    .req     (dpd_req),
    .pending (pend)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      PS_INIT, PS_EXIT: if (tmr_done) state_d = (pend || dpd_req) ? PS_DEEP : PS_READY;
      PS_READY:         if (dpd_req)  state_d = PS_DEEP;
      PS_DEEP:          if (wake_req) state_d = PS_EXIT;
      default:          state_d = PS_INIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_INIT;
    else        state_q <= state_d;
  end

  assign enter_deep = (state_d == PS_DEEP) && (state_q != PS_DEEP);

  pwr_lost_flag u_lost (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (enter_deep),
    .clr   (lost_clr),
    .lost  (contents_lost)
  );

  assign dpd_pin_n     = (state_q != PS_DEEP);
  assign ce_force_high = (state_q != PS_READY);
  assign mem_ready     = (state_q == PS_READY);

  // R3
  deep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dpd_pin_n) |-> ($past(dpd_req) || $past(pend)));

  // R2
  ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ready) |-> $past(tmr_done));

  // R8
  ce_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dpd_pin_n) |-> ce_force_high);

  // R4
  lost_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(contents_lost) |-> !dpd_pin_n);

endmodule

// File: tb/psram_pwr_seq_test.sv
`timescale 1ns/1ps
module psram_pwr_seq_test;

  localparam int W = 20; // 100 kHz x 200 us

  logic clk = 1'b0;
  logic rst_n, dpd_req, wake_req, lost_clr;
  logic dpd_pin_n, ce_force_high, mem_ready, contents_lost;

  always #2.5 clk = ~clk;

  psram_pwr_seq #(.CLK_FREQ_HZ(100_000), .WAIT_US(200)) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .dpd_req       (dpd_req),
    .wake_req      (wake_req),
    .lost_clr      (lost_clr),
    .dpd_pin_n     (dpd_pin_n),
    .ce_force_high (ce_force_high),
    .mem_ready     (mem_ready),
    .contents_lost (contents_lost)
  );

  typedef struct {
    int    cyc;
    logic  [3:0] val; // {pin, ce, rdy, lost}
    string tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int checks = 0;
  int fails = 0;
  int c = 0;
  bit done_flag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops expectations that are due
  always @(posedge clk) begin
    #1;
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      exp_t e;
      logic [3:0] act;
      e = q.pop_front();
      act = {dpd_pin_n, ce_force_high, mem_ready, contents_lost};
      checks++;
      if (e.cyc < cyc) begin
        fails++;
        $display("FAIL %s: expectation for cycle %0d missed (now %0d), expected %b", e.tag, e.cyc, cyc, e.val);
      end else if (act !== e.val) begin
        fails++;
        $display("FAIL %s: cycle %0d {pin,ce,rdy,lost} actual %b expected %b", e.tag, cyc, act, e.val);
      end
    end
  end

  task automatic expect_at(input int k, input logic [3:0] v, input string tag);
    exp_t e;
    e.cyc = k; e.val = v; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic start(input logic d, input logic w, input logic l);
    @(negedge clk);
    dpd_req = d; wake_req = w; lost_clr = l;
    c = cyc;
  endtask

  task automatic stop();
    @(negedge clk);
    dpd_req = 1'b0; wake_req = 1'b0; lost_clr = 1'b0;
  endtask

  task automatic wait_until(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not end, actual hung expected finished");
    finish_run();
  end

  initial begin
    int r, c0;
    rst_n = 1'b0; dpd_req = 1'b0; wake_req = 1'b0; lost_clr = 1'b0;
    repeat (3) @(negedge clk);
    expect_at(cyc + 1, 4'b1100, "R1 reset state");
    @(negedge clk);
    rst_n = 1'b1;
    r = cyc;

    // R7: wake during the init wait does nothing
    start(0, 1, 0);
    expect_at(c + 1, 4'b1100, "R7 wake in init");
    stop();
    expect_at(r + W - 1, 4'b1100, "R2 not ready yet");
    expect_at(r + W, 4'b1010, "R2/R8 ready after W");
    wait_until(r + W + 1);

    // R7: wake while ready does nothing
    start(0, 1, 0);
    expect_at(c + 1, 4'b1010, "R7 wake in ready");
    stop();

    // R3 and R4: enter deep power down
    start(1, 0, 0);
    c0 = c;
    expect_at(c + 1, 4'b0101, "R3 deep entry");
    stop();
    // R7: dpd_req while deep does nothing
    start(1, 0, 0);
    expect_at(c + 1, 4'b0101, "R7 dpd in deep");
    stop();
    expect_at(c0 + 5, 4'b0101, "R4 lost held");
    wait_until(c0 + 6);

    // R5: wake and exit wait
    start(0, 1, 0);
    expect_at(c + 1, 4'b1101, "R5 pin high, not ready");
    expect_at(c + W, 4'b1101, "R5/R8 still waiting");
    expect_at(c + W + 1, 4'b1011, "R5 ready after exit wait");
    stop();
    wait_until(c + W + 2);

    // R4: clear, then set-wins, then clear in deep
    start(0, 0, 1);
    expect_at(c + 1, 4'b1010, "R4 clear in ready");
    stop();
    start(1, 0, 1);
    expect_at(c + 1, 4'b0101, "R4 set wins over clear");
    stop();
    start(0, 0, 1);
    expect_at(c + 1, 4'b0100, "R4 clear in deep");
    stop();

    // R6: dpd request held during exit wait
    start(0, 1, 0);
    c0 = c;
    expect_at(c0 + 1, 4'b1100, "R5 wake again");
    stop();
    wait_until(c0 + 5);
    start(1, 0, 0);
    stop();
    expect_at(c0 + W, 4'b1100, "R6 wait still running");
    expect_at(c0 + W + 1, 4'b0101, "R6 held request enters deep");
    wait_until(c0 + W + 3);

    // R1: reset again clears the lost flag; R6 request held in init wait
    @(negedge clk);
    rst_n = 1'b0;
    expect_at(cyc + 1, 4'b1100, "R1 reset clears lost");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    r = cyc;
    start(1, 0, 0);
    expect_at(r + W - 1, 4'b1100, "R6 init wait running");
    expect_at(r + W, 4'b0101, "R6 held request after init");
    stop();
    wait_until(r + W + 2);

    start(0, 1, 0);
    expect_at(c + W + 1, 4'b1011, "R5 ready after final wake");
    stop();
    wait_until(c + W + 3);

    while (q.size() > 0) @(negedge clk);
    finish_run();
  end

endmodule